// File: doc/BRIEF.md
# Manchester Load-Modulation Reply Transmitter

This block plays the tag side of a low-frequency link. When the frame decoder asks for a reply, the block waits for the reply slot. It then drives a single coil-load output with a Manchester pattern: a fixed start marker of five ones, followed by up to 80 data bits. All timing is counted in carrier periods. One carrier period is a programmable number of clock ticks, so the same logic serves different carrier and clock ratios.

The reply slot is measured from the most recent rising edge that the receiver reports on the reader field. The requested delay is trimmed by 8 carrier periods to allow for the reader's gap time. A nominal request is 208 periods, and the usable range is 204 to 212. The frame, its length and the delay are captured when a request is accepted. The block then stays busy until the coil has been released after the last bit. Requests that arrive in the meantime are dropped.

Top module: `lf_manchester_tx`

## Requirements
- R1: After reset, `coil_load` is 0 and `busy` is 0.
- R2: A `start` sampled while not busy is accepted: `busy` is 1 from the next cycle on, and `coil_load` stays 0 until the first bit cell begins.
- R3: Let `k` be the clock edge that samples the last `rdr_rise` pulse, `s` the edge that accepts `start`, T the ticks per period, and D = max(`reply_delay` − 8, 0). The first bit cell begins at edge e = max(s+1, k+1+D·T), and `coil_load` is 1 from that edge on.
- R4: Each frame begins with five 1 bits, before any data bit.
- R5: A bit cell is 31 carrier periods of T clocks each, timed from the start of that cell. A 1 bit is loaded (`coil_load`=1) in periods 0 to 14 and unloaded in periods 15 to 30. A 0 bit is the reverse.
- R6: Data bit j (j = 0 first) is `frame_data[79−j]`. Byte 0 sits in bits 79 to 72, and each byte is sent MSB first.
- R7: For a frame of N cells (5 plus the data length), `coil_load` and `busy` both go to 0 at edge e + N·31·T.
- R8: A `start` sampled while busy is ignored. Changes to `frame_data`, `frame_len` or `reply_delay` after acceptance do not alter the frame being sent.
- R9: `frame_len` = 0 sends only the five-bit marker. A `frame_len` above 80 is treated as 80.
- R10: `ticks_per_period` = 0 behaves as 1.
- R11: An `rdr_rise` pulse during the wait restarts the delay measurement from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ticks_per_period | input | 8 | Clock ticks per carrier period (0 acts as 1); held steady |
| rdr_rise | input | 1 | One-cycle pulse on each rising edge of the reader field |
| start | input | 1 | Reply request from the decoder |
| frame_data | input | 80 | Reply bits, sent from bit 79 downward |
| frame_len | input | 7 | Number of data bits (clamped to 80) |
| reply_delay | input | 9 | Requested reply time in carrier periods after the last rising edge |
| coil_load | output | 1 | 1 = coil loaded, 0 = unloaded |
| busy | output | 1 | High from acceptance until the final unload |

## Verification
Two functions can fall in the same cycle. A fresh request can arrive while a frame is being sent, and a reader rising edge can arrive while the block is waiting for its slot. The bench issues a second `start` with different data, length and delay in the middle of a transmission. It also pulses `rdr_rise` partway through a wait. For every cycle of every frame, the bench compares `coil_load` and `busy` with a waveform it derives arithmetically from R3 to R7. A request that was wrongly accepted, or a delay that was not restarted, therefore shows up as a shifted or altered waveform. The bench also reports the exact cycle in which the first load occurs.

// File: rtl/lf_tx_pkg.sv
package lf_tx_pkg;
  localparam int MAX_BITS = 80;  // largest data payload
  localparam int PRE_BITS = 5;   // start marker length, all ones
  localparam int HALF_P   = 15;  // period index of the mid-cell transition
  localparam int CELL_P   = 31;  // periods per bit cell
  localparam int GAP_P    = 8;   // reader gap trim on the reply delay
  localparam int TICK_W   = 8;
  localparam int DLY_W    = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/lf_tx_ticker.sv
// Divides the clock into carrier periods; restart realigns the phase.
module lf_tx_ticker #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [TICK_W-1:0] ticks_per_period,
  output logic              period_end
);
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] last;

  assign last       = (ticks_per_period == '0) ? '0 : ticks_per_period - 1'b1;
  assign period_end = !restart && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || restart)      cnt_q <= '0;
    else if (cnt_q >= last)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lf_tx_age.sv
// Carrier periods elapsed since the last reader rising edge (saturating).
module lf_tx_age #(
  parameter int TICK_W = 8,
  parameter int DLY_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdr_rise,
  input  logic [TICK_W-1:0] ticks_per_period,
  output logic [DLY_W-1:0]  age
);
  logic per_end;
  logic [DLY_W-1:0] age_q;

  lf_tx_ticker #(.TICK_W(TICK_W)) u_tick (
    .clk(clk), .rst(rst), .restart(rdr_rise),
    .ticks_per_period(ticks_per_period), .period_end(per_end)
  );

  always_ff @(posedge clk) begin
    if (rst || rdr_rise)                  age_q <= '0;
    else if (per_end && (age_q != '1))    age_q <= age_q + 1'b1;
  end

  assign age = age_q;

  // Without a new edge the elapsed count never moves backward.
  assert_age_mono_R11: assert property (@(posedge clk) disable iff (rst)
    !rdr_rise |=> (age_q >= $past(age_q)));
endmodule

// File: rtl/lf_tx_bitsel.sv
// Holds the captured frame and returns the level of any cell index.
module lf_tx_bitsel #(
  parameter int MAX_BITS = 80,
  parameter int PRE_BITS = 5,
  parameter int LEN_W    = $clog2(MAX_BITS + 1),
  parameter int IDX_W    = $clog2(MAX_BITS + PRE_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic [IDX_W-1:0]    idx,
  output logic                bit_val,
  output logic [IDX_W-1:0]    total_bits
);
  logic [MAX_BITS-1:0] frame_q;
  logic [LEN_W-1:0]    len_q;
  logic [LEN_W-1:0]    len_clamped;
  logic [IDX_W-1:0]    rel;
  logic [MAX_BITS-1:0] shifted;

  assign len_clamped = (frame_len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : frame_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      len_q   <= '0;
    end else if (load) begin
      frame_q <= frame_data;
      len_q   <= len_clamped;
    end
  end

  assign total_bits = IDX_W'(PRE_BITS) + IDX_W'(len_q);
  assign rel        = idx - IDX_W'(PRE_BITS);
  assign shifted    = frame_q << rel;

  always_comb begin
    if (idx < IDX_W'(PRE_BITS))  bit_val = 1'b1;
    else if (idx < total_bits)   bit_val = shifted[MAX_BITS-1];
    else                         bit_val = 1'b0;
  end

  // Stored length never exceeds the payload capacity.
  assert_len_clamp_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (len_q <= LEN_W'(MAX_BITS)));
endmodule

// File: rtl/lf_manchester_tx.sv
module lf_manchester_tx
  import lf_tx_pkg::*;
#(
  parameter int MAX_BITS_P = lf_tx_pkg::MAX_BITS,
  parameter int PRE_BITS_P = lf_tx_pkg::PRE_BITS,
  parameter int HALF_PP    = lf_tx_pkg::HALF_P,
  parameter int CELL_PP    = lf_tx_pkg::CELL_P,
  parameter int GAP_PP     = lf_tx_pkg::GAP_P,
  parameter int TICK_WP    = lf_tx_pkg::TICK_W,
  parameter int DLY_WP     = lf_tx_pkg::DLY_W,
  parameter int LEN_WP     = $clog2(MAX_BITS_P + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TICK_WP-1:0]    ticks_per_period,
  input  logic                  rdr_rise,
  input  logic                  start,
  input  logic [MAX_BITS_P-1:0] frame_data,
  input  logic [LEN_WP-1:0]     frame_len,
  input  logic [DLY_WP-1:0]     reply_delay,
  output logic                  coil_load,
  output logic                  busy
);
  localparam int IDX_W = $clog2(MAX_BITS_P + PRE_BITS_P + 1);
  localparam int PC_W  = $clog2(CELL_PP);

  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [DLY_WP-1:0] dly_q, target, age;
  logic              coil_q, coil_d, busy_q, busy_d;
  logic              accept, go, launch, per_end, bit_val;
  logic [IDX_W-1:0]  total_bits;

  assign accept = (state_q == ST_IDLE) && start;
  assign target = (dly_q >= DLY_WP'(GAP_PP)) ? dly_q - DLY_WP'(GAP_PP) : '0;
  assign go     = (age >= target);
  assign launch = (state_q == ST_WAIT) && go;

  lf_tx_age #(.TICK_W(TICK_WP), .DLY_W(DLY_WP)) u_age (
    .clk(clk), .rst(rst), .rdr_rise(rdr_rise),
    .ticks_per_period(ticks_per_period), .age(age)
  );

  lf_tx_ticker #(.TICK_W(TICK_WP)) u_cell_tick (
    .clk(clk), .rst(rst), .restart(launch),
    .ticks_per_period(ticks_per_period), .period_end(per_end)
  );

  lf_tx_bitsel #(
    .MAX_BITS(MAX_BITS_P), .PRE_BITS(PRE_BITS_P), .LEN_W(LEN_WP), .IDX_W(IDX_W)
  ) u_bits (
    .clk(clk), .rst(rst), .load(accept),
    .frame_data(frame_data), .frame_len(frame_len),
    .idx(idx_d), .bit_val(bit_val), .total_bits(total_bits)
  );

  // Sequencing: wait for the slot, then step periods and cells.
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pc_d    = pc_q;
    busy_d  = busy_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_WAIT;
          busy_d  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (go) begin
          state_d = ST_SEND;
          idx_d   = '0;
          pc_d    = '0;
        end
      end
      ST_SEND: begin
        if (per_end) begin
          if (pc_q == PC_W'(CELL_PP - 1)) begin
            pc_d = '0;
            if (idx_q == total_bits - 1'b1) begin
              state_d = ST_IDLE;
              idx_d   = '0;
              busy_d  = 1'b0;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            pc_d = pc_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        busy_d  = 1'b0;
      end
    endcase
  end

  // Coil level for the upcoming cycle: ones load first, zeros load second.
  always_comb begin
    if (state_d == ST_SEND)
      coil_d = bit_val ? (pc_d < PC_W'(HALF_PP)) : (pc_d >= PC_W'(HALF_PP));
    else
      coil_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pc_q    <= '0;
      coil_q  <= 1'b0;
      busy_q  <= 1'b0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pc_q    <= pc_d;
      coil_q  <= coil_d;
      busy_q  <= busy_d;
      if (accept) dly_q <= reply_delay;
    end
  end

  assign coil_load = coil_q;
  assign busy      = busy_q;

  // Coil never loaded while not busy.
  assert_idle_unloaded_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !coil_q);

  // First busy cycle is still unloaded (waiting for the slot).
  assert_wait_unloaded_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !coil_q);

  // Marker cells are loaded in their first half.
  assert_marker_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND && idx_q < IDX_W'(PRE_BITS_P) && pc_q < PC_W'(HALF_PP)) |-> coil_q);

  // Period index stays inside one cell.
  assert_cell_bound_R5: assert property (@(posedge clk) disable iff (rst)
    pc_q < PC_W'(CELL_PP));

  // A request while busy leaves the captured delay untouched.
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start) |=> (dly_q == $past(dly_q)));
endmodule

// File: tb/lf_manchester_tx_tb.sv
`timescale 1ns/1ps
module lf_manchester_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tpp = 8'd1;
  logic        rdr_rise = 1'b0;
  logic        start = 1'b0;
  logic [79:0] frame_data = '0;
  logic [6:0]  frame_len = '0;
  logic [8:0]  reply_delay = '0;
  logic        coil_load, busy;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lf_manchester_tx u_dut (
    .clk(clk), .rst(rst), .ticks_per_period(tpp), .rdr_rise(rdr_rise),
    .start(start), .frame_data(frame_data), .frame_len(frame_len),
    .reply_delay(reply_delay), .coil_load(coil_load), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [79:0] mkdata(input logic [15:0] seed);
    logic [79:0] v = '0;
    logic [15:0] x = seed;
    for (int i = 0; i < 80; i++) begin
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      v = {v[78:0], x[0]};
    end
    return v;
  endfunction

  // Drives one reply and compares every cycle against the arithmetic model.
  task automatic run_frame(input int t, input logic [79:0] d, input int len,
                           input int dly, input int gap, input int mid_rise,
                           input int mid_start, input string tag);
    int te, lenc, n, tgt, k, k2, s, e, endc, x, o, nb, p, first_load;
    int cerr, berr, cx, cact, cexp;
    logic b, expc, expb;
    te = (t == 0) ? 1 : t;
    lenc = (len > 80) ? 80 : len;
    n = 5 + lenc;
    tgt = (dly >= 8) ? dly - 8 : 0;
    cerr = 0; berr = 0; cx = -1; cact = 0; cexp = 0; first_load = -1; k2 = -1;
    tpp = 8'(t); frame_data = d; frame_len = 7'(len); reply_delay = 9'(dly);
    @(negedge clk); rdr_rise = 1'b1; k = cyc + 1;
    @(negedge clk); rdr_rise = 1'b0;
    repeat (gap) @(negedge clk);
    start = 1'b1; s = cyc + 1;
    @(negedge clk); start = 1'b0;
    if (mid_rise > 0) begin
      k2 = s + mid_rise;
      e = k2 + 1 + tgt * te;
    end else begin
      e = k + 1 + tgt * te;
    end
    if (e < s + 1) e = s + 1;
    endc = e + n * 31 * te;
    while (cyc <= endc + 3) begin
      x = cyc;
      expc = 1'b0;
      if (x >= e && x < endc) begin
        o = x - e;
        nb = o / (31 * te);
        p = (o % (31 * te)) / te;
        b = (nb < 5) ? 1'b1 : d[79 - (nb - 5)];
        expc = b ? (p < 15) : (p >= 15);
      end
      expb = (x >= s && x < endc);
      if (coil_load !== expc) begin
        if (cerr == 0) begin cx = x - e; cact = int'(coil_load); cexp = int'(expc); end
        cerr++;
      end
      if (busy !== expb) berr++;
      if (coil_load === 1'b1 && first_load < 0) first_load = x;
      rdr_rise = (k2 > 0 && x == k2 - 1);
      if (mid_start > 0 && x == s + mid_start) begin
        start = 1'b1;
        frame_data = ~d;
        frame_len = 7'd3;
        reply_delay = 9'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    check(cerr == 0, tag, $sformatf("coil waveform mismatches (first at cell offset %0d, got %0d want %0d)", cx, cact, cexp), cerr, 0);
    check(berr == 0, tag, "busy waveform mismatches", berr, 0);
    check(first_load == e, tag, "first loaded cycle R3", first_load, e);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(coil_load === 1'b0, "R1", "coil_load during reset", int'(coil_load), 0);
    check(busy === 1'b0, "R1", "busy during reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    check(coil_load === 1'b0 && busy === 1'b0, "R1", "outputs after reset", int'({coil_load, busy}), 0);

    // Nominal delay, 16 data bits.
    run_frame(1, 80'hB4E1_5A5A_F00F_1234_C3A5, 16, 208, 3, 0, 0, "R2 R3 R4 R5 R6 R7");
    // Marker only.
    run_frame(2, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 0, 204, 2, 0, 0, "R9 R4");
    // Slot already passed at acceptance, full-length frame.
    run_frame(3, mkdata(16'h1D3B), 80, 10, 40, 0, 0, "R3 R6");
    // Zero ticks per period acts as one; delay exactly the trim.
    run_frame(0, 80'h0123_4567_89AB_CDEF_F0F0, 8, 8, 2, 0, 0, "R10");
    // Oversize length clamps; second start during wait and again mid-send.
    run_frame(2, mkdata(16'hACE1), 100, 208, 3, 0, 150, "R8 R9");
    run_frame(2, mkdata(16'h7777), 20, 206, 3, 0, 600, "R8");
    // Reader edge during the wait restarts the delay.
    run_frame(1, 80'hF0F0_0F0F_AAAA_5555_1111, 12, 60, 3, 20, 0, "R11");
    // Delay below the trim behaves as zero.
    run_frame(1, 80'h8000_0000_0000_0000_0001, 2, 3, 2, 0, 0, "R3");

    // Sweep of carrier ratios and lengths inside the valid delay window.
    for (int t = 1; t <= 3; t++) begin
      for (int li = 0; li < 3; li++) begin
        int len;
        len = (li == 0) ? 1 : (li == 1) ? 13 : 40;
        run_frame(t, mkdata(16'(t * 97 + li * 13 + 5)), len, 204 + (t * len) % 9, 2, 0, 0,
                  "R3 R5 R6 R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule